// File: doc/BRIEF.md
# NCO baud tick generator

This block sets the bit timing of a serial port with a fractional phase accumulator rather than an integer divider. On every system clock edge it adds a 16-bit increment to a 20-bit phase register. Each time the sum passes 2^20 it raises a one-cycle bit tick. The bit rate is therefore increment × f_clk / 2^20. The increment can be any integer, so the rate is not limited to whole divisions of the clock.

A second stage counts bit ticks and raises a character tick on every tenth one. Ten bit periods cover one start bit, eight data bits and one stop bit, so the character tick marks the end of a framed byte. A shift register or a receiver in a neighbouring block uses the two ticks as its time base. The increment is read directly from a control field, so a new value applies at the very next clock edge. Dropping the enable returns both counters to zero.

Top module: `baud_nco_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase register and the character count clear, and `bit_tick` and `char_tick` are low after that edge.
- R2: At each enabled edge, `incr` is added to the 20-bit phase register, which keeps the low 20 bits of the sum. `bit_tick` is high for exactly the cycle after an edge whose sum reaches 2^20. Starting from a cleared register with `incr` = 0x8000, the first tick follows edge 32.
- R3: With `incr` = 0, no bit tick and no character tick is produced.
- R4: `char_tick` is high in the same cycle as every tenth `bit_tick` counted from a clear, and in no other cycle.
- R5: When `en` is low at an edge, the phase register and the character count clear, and both ticks are low after that edge, even if a carry was due there.
- R6: A changed `incr` is used by the first edge after the change.
- R7: `bit_tick` is never high in two consecutive cycles.
- R8: Over N enabled edges from a clear with a constant `incr`, the number of bit ticks is floor(N × incr / 2^20), and the number of character ticks is that count divided by ten, rounded down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low clears the phase register and the character count |
| incr | input | 16 | Phase increment added at each clock edge |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| char_tick | output | 1 | One-cycle pulse on every tenth bit tick |

## Verification
The tenth bit tick and the character tick must land in the same cycle. This is provoked with a rate of exactly 32 clocks per bit, and the bench checks that both outputs are high after edge 320 and that neither is high after edge 319. A second collision puts a clearing event and a due carry on the same edge. The enable, or the reset, is dropped just before edge 32 of such a run, and the bench checks that the clear wins: no tick appears, and after the block is enabled again the next bit tick comes a full 32 clocks later.

// File: rtl/baud_nco_pkg.sv
// Package: shared defaults for the NCO baud tick generator.
// Assumes: every width and count in the block derives from these values.
package baud_nco_pkg;
    localparam int unsigned DEF_INC_W     = 16; // increment field width
    localparam int unsigned DEF_ACC_W     = 20; // phase register width
    localparam int unsigned DEF_CHAR_BITS = 10; // bit periods per character

    // Width of a counter that holds 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/nco_phase_acc.sv
// Module: nco_phase_acc
// Adds the increment to a phase register on every enabled clock edge.
// Exposes the carry of the current sum as a combinational signal and a
// registered tick that is high for the cycle after each wrap.
// Assumes ACC_W > INC_W, so one addition can wrap the register at most once.
module nco_phase_acc #(
    parameter int unsigned INC_W = 16,
    parameter int unsigned ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [INC_W-1:0] incr,
    output logic             carry_c,
    output logic             tick_q
);
    localparam int unsigned SUM_W = ACC_W + 1;
    localparam int unsigned PAD_W = SUM_W - INC_W;

    logic [ACC_W-1:0] phase_q;
    logic [SUM_W-1:0] sum_c;

    // Next phase value, with the carry in the top bit
    always_comb begin
        sum_c   = {1'b0, phase_q} + {{PAD_W{1'b0}}, incr};
        carry_c = en & sum_c[SUM_W-1];
    end

    // Phase register and registered tick; a reset or disable clears both
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            phase_q <= sum_c[ACC_W-1:0];
            tick_q  <= sum_c[SUM_W-1];
        end
    end
endmodule

// File: rtl/char_slot_cnt.sv
// Module: char_slot_cnt
// Counts bit steps and raises a registered pulse on the step that completes
// a character of SLOTS bit periods.
// Assumes step is the combinational carry, so the pulse lines up with the
// registered bit tick.
module char_slot_cnt #(
    parameter int unsigned SLOTS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    output logic done_q
);
    localparam int unsigned CNT_W = baud_nco_pkg::cnt_width(SLOTS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

    logic [CNT_W-1:0] slot_q;
    logic             at_last_c;

    // Marks the final slot of a character
    always_comb at_last_c = (slot_q == LAST);

    // Slot counter and character pulse; a reset or disable restarts them
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            slot_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= step & at_last_c;
            if (step) begin
                slot_q <= at_last_c ? '0 : slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/baud_nco_gen.sv
// Module: baud_nco_gen (top)
// Bit and character timing for a serial port, driven by a fractional
// phase accumulator: bit rate = incr * f_clk / 2^ACC_W.
// Assumes incr is stable or changes only between edges; a change
// applies at the next edge.
module baud_nco_gen #(
    parameter int unsigned INC_W     = baud_nco_pkg::DEF_INC_W,
    parameter int unsigned ACC_W     = baud_nco_pkg::DEF_ACC_W,
    parameter int unsigned CHAR_BITS = baud_nco_pkg::DEF_CHAR_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [INC_W-1:0] incr,
    output logic             bit_tick,
    output logic             char_tick
);
    logic carry_w;

    nco_phase_acc #(
        .INC_W (INC_W),
        .ACC_W (ACC_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .incr    (incr),
        .carry_c (carry_w),
        .tick_q  (bit_tick)
    );

    char_slot_cnt #(
        .SLOTS (CHAR_BITS)
    ) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .step   (carry_w),
        .done_q (char_tick)
    );
endmodule

// File: rtl/baud_nco_chk.sv
// Module: baud_nco_chk
// Temporal properties on the ports of baud_nco_gen, attached by bind.
// Assumes incr is narrower than ACC_W-1 bits, so two wraps in a row
// cannot happen.
module baud_nco_chk #(
    parameter int unsigned INC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [INC_W-1:0] incr,
    input logic             bit_tick,
    input logic             char_tick
);
    // R1: a reset edge leaves both ticks low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bit_tick && !char_tick));

    // R3: a zero increment cannot wrap the phase register
    a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en && incr == '0) |=> !bit_tick);

    // R4: a character tick only comes with a bit tick
    a_r4_char_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
        char_tick |-> bit_tick);

    // R5: a disabled edge leaves both ticks low
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bit_tick && !char_tick));

    // R7: no bit tick in two consecutive cycles
    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

bind baud_nco_gen baud_nco_chk #(
    .INC_W (INC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .incr      (incr),
    .bit_tick  (bit_tick),
    .char_tick (char_tick)
);

// File: tb/sim_baud_nco_gen.sv
module sim_baud_nco_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] incr = 16'h0;
    logic        bit_tick;
    logic        char_tick;

    int checks = 0;
    int fails  = 0;
    int b2b_total = 0;

    baud_nco_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .incr      (incr),
        .bit_tick  (bit_tick),
        .char_tick (char_tick)
    );

    always #10 clk = ~clk; // 50 MHz

    // columns: increment, edges, expected bit ticks, expected char ticks
    localparam int unsigned VEC [8][4] = '{
        '{32'h8000,  320, 10, 1},
        '{32'hFFFF,  200, 12, 1},
        '{32'h0001, 2000,  0, 0},
        '{32'h4000,  640, 10, 1},
        '{32'h1234, 3000, 13, 1},
        '{32'h2000, 1280, 10, 1},
        '{32'hFFFF, 1600, 99, 9},
        '{32'h0000,  500,  0, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // one clock edge, then settle to the falling edge for sampling/driving
    task automatic edge1();
        @(posedge clk);
        @(negedge clk);
    endtask

    // clear with a disabled edge, then enable with the given increment
    task automatic restart(input logic [15:0] v);
        en = 1'b0;
        edge1();
        incr = v;
        en = 1'b1;
    endtask

    task automatic run(input int n, output int bits, output int chars);
        int prev = 0;
        bits = 0;
        chars = 0;
        for (int i = 0; i < n; i++) begin
            edge1();
            bits  += int'(bit_tick);
            chars += int'(char_tick);
            if (bit_tick && prev != 0) b2b_total++;
            prev = int'(bit_tick);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int nb, nc, first;
        @(negedge clk);
        // R1: reset holds outputs low even with enable and a large increment
        en = 1'b1;
        incr = 16'hFFFF;
        for (int i = 0; i < 40; i++) begin
            edge1();
            if (bit_tick || char_tick) nb++;
        end
        check("R1 reset quiet", nb, 0);
        rst_n = 1'b1;

        // R8 and R3: table of rates
        for (int k = 0; k < 8; k++) begin
            restart(16'(VEC[k][0]));
            run(int'(VEC[k][1]), nb, nc);
            check($sformatf("R8 bits vec%0d", k), nb, int'(VEC[k][2]));
            check($sformatf("R8 R3 chars vec%0d", k), nc, int'(VEC[k][3]));
        end
        check("R7 no back-to-back ticks", b2b_total, 0);

        // R2 and R4: exact tick placement at 32 clocks per bit
        restart(16'h8000);
        run(31, nb, nc);
        check("R2 no tick by edge 31", nb, 0);
        edge1();
        check("R2 tick after edge 32", int'(bit_tick), 1);
        edge1();
        check("R2 tick one cycle", int'(bit_tick), 0);
        run(286, nb, nc);
        check("R4 no char by edge 319", nc, 0);
        check("R4 nine bits before char", nb, 8);
        edge1();
        check("R4 char after edge 320", int'(char_tick), 1);
        check("R4 bit with char", int'(bit_tick), 1);

        // R5: disable on the edge where a carry is due
        restart(16'h8000);
        run(31, nb, nc);
        en = 1'b0;
        edge1();
        check("R5 carry suppressed", int'(bit_tick), 0);

        // R5: disable clears phase and character count
        restart(16'h8000);
        run(170, nb, nc);
        en = 1'b0;
        edge1();
        check("R5 outputs low when off", int'(bit_tick) + int'(char_tick), 0);
        en = 1'b1;
        first = 0;
        for (int i = 1; i <= 320; i++) begin
            edge1();
            if (bit_tick && first == 0) first = i;
            if (char_tick) begin
                check("R5 char restarts from zero", i, 320);
            end
        end
        check("R5 phase restarts from zero", first, 32);

        // R1: reset on the edge where a carry is due
        restart(16'h8000);
        run(31, nb, nc);
        rst_n = 1'b0;
        edge1();
        check("R1 reset beats carry", int'(bit_tick), 0);
        rst_n = 1'b1;
        run(32, nb, nc);
        check("R1 phase cleared by reset", nb, 1);

        // R6: new increment used at the next edge
        restart(16'h8000);
        run(31, nb, nc);
        incr = 16'h0001;
        edge1();
        check("R6 small incr stops tick", int'(bit_tick), 0);
        incr = 16'h8000;
        edge1();
        check("R6 restored incr ticks", int'(bit_tick), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule